// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Pin

This block drives or watches one serial line. Its bit timing comes from a 16-bit phase accumulator, not from an integer divider. On every clock the accumulator adds a baud increment. Each carry out of the top bit ends one bit period. The increment is round(65536 × baud / f_clk), so a baud rate that is not an integer fraction of the clock is still met on average.

A mode input chooses the transmitter or the receiver. A 32-bit configuration word holds the increment and the character length.

In transmit mode, a write of a data word sends one frame on `pin_o`, and the top bit of `result_o` reports that the frame is still going out. In receive mode, a character that arrives on `pin_i` lands in a single holding register and raises `flag_o`. An acknowledge releases it. If a second character arrives before the acknowledge, it replaces the first and `ovr_o` is raised.

Top module: `nco_serial_pin`

## Requirements
- R1: `cfg_i[31:16]` holds the increment `inc`. Bit periods end at the carries of a 16-bit accumulator that advances by `inc` each cycle. When a frame of P periods starts at edge W, its last period ends at edge W+m, where m is the smallest integer with m·inc ≥ P·65536.
- R2: `cfg_i[4:0]` holds the character length minus one, so 1 to 32 data bits are possible. A value of 7 means 8 data bits.
- R3: A transmitted frame has three parts, in this order:
  - one low start bit;
  - the data bits, least significant first;
  - one high stop bit.
  The line is high at all other times.
- R4: With `mode_i`=0, a write (`wr_i`) accepted while idle drives `pin_o` low and raises busy from the following cycle. The write also clears the accumulator.
- R5: `result_o[31]` is busy in transmit mode. It stays 1 for the whole frame and falls at the edge that ends the stop bit. A write made while busy is ignored.
- R6: With `mode_i`=1, a falling edge on `pin_i` starts reception. Bits are sampled at mid-period. After the stop sample, `flag_o` is set and the data appears in `result_o`, right-justified and zero above the configured length.
- R7: When the start-bit sample at half a period finds the line high again, reception is abandoned. No flag is raised, and the next falling edge starts a new reception.
- R8: `ack_i` clears `flag_o` and `ovr_o` on the next edge. If a character completes in the same cycle as the acknowledge, the flag stays set and the overrun stays clear.
- R9: A character that completes while `flag_o` is set replaces the held data and sets `ovr_o`.
- R10: In receive mode, `pin_o` is held high and `wr_i` has no effect. On return to transmit mode, busy reads 0.
- R11: After reset, `pin_o` is 1, and `flag_o`, `ovr_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = transmit, 1 = receive |
| cfg_i | input | 32 | [31:16] baud increment, [4:0] data bits minus one |
| wr_i | input | 1 | Write strobe that starts a transmit frame |
| wdata_i | input | 32 | Character to transmit |
| ack_i | input | 1 | Releases the received character |
| pin_i | input | 1 | Serial line input |
| pin_o | output | 1 | Serial line output |
| result_o | output | 32 | Transmit: busy in bit 31; receive: held character |
| flag_o | output | 1 | Received character waiting |
| ovr_o | output | 1 | A held character was overwritten |

## Verification
The checker watches the following on every cycle:
- the line is high whenever the transmitter is idle or the receiver is selected;
- an accepted write gives a low start bit and busy on the next cycle;
- busy only ever drops out of a high stop bit;
- the receive flag holds until it is acknowledged;
- overrun implies the flag, and an acknowledge always clears overrun.

Some behaviour can only be shown by the bench's scenarios, because it depends on whole frames:
- the exact bit order and the sampling points;
- the frame length in cycles at fractional increments such as 2458 and 94;
- zero-extension of short characters;
- rejection of a glitch shorter than half a bit;
- which character is kept after an overrun.

// File: rtl/nco_serial_pkg.sv
package nco_serial_pkg;
  localparam int unsigned ACC_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W = 5;
  localparam int unsigned CFG_W = 32;

  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign tick_o = sum[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= load_val_i;
    else             acc_q <= sum[W-1:0];
  end
endmodule

// File: rtl/nco_serial_tx.sv
module nco_serial_tx #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              tick_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int unsigned SH_W = DATA_W + 2;

  logic              busy_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] keep, padded;

  // bits beyond the configured length read as stop level
  always_comb begin
    keep = '0;
    for (int i = 0; i < int'(DATA_W); i++)
      if (i <= int'(len_m1_i)) keep[i] = 1'b1;
    padded = data_i | ~keep;
  end

  assign start_o = en_i & wr_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
    end else if (start_o) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, padded, 1'b0};
      left_q <= CNT_W'(len_m1_i) + CNT_W'(3);
    end else if (busy_q && tick_i) begin
      if (left_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        sh_q   <= '1;
      end else begin
        left_q <= left_q - CNT_W'(1);
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/nco_serial_rx.sv
module nco_serial_rx #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pin_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              tick_i,
  input  logic              ack_i,
  output logic              start_o,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_o,
  output logic              ovr_o
);
  logic              s1_q, s2_q, last_q;
  logic              active_q;
  logic [CNT_W-1:0]  idx_q, nbits;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              flag_q, ovr_q, done;

  assign nbits   = CNT_W'(len_m1_i) + CNT_W'(1);
  assign start_o = en_i & ~active_q & ~s2_q & last_q;
  assign done    = en_i & active_q & tick_i & (idx_q == nbits + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      last_q <= 1'b1;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      last_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      sh_q     <= '0;
    end else if (active_q && tick_i) begin
      if (idx_q == '0) begin
        // start bit must still be low at mid-bit
        if (s2_q) active_q <= 1'b0;
        else      idx_q    <= CNT_W'(1);
      end else if (idx_q <= nbits) begin
        sh_q  <= sh_q | (DATA_W'(s2_q) << (idx_q - CNT_W'(1)));
        idx_q <= idx_q + CNT_W'(1);
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (done) begin
      data_q <= sh_q;
      flag_q <= 1'b1;
      ovr_q  <= flag_q & ~ack_i;
    end else if (ack_i) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/nco_serial_pin.sv
module nco_serial_pin
  import nco_serial_pkg::*;
#(
  parameter int unsigned P_ACC_W  = ACC_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_LEN_W  = LEN_W,
  parameter int unsigned P_CFG_W  = CFG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic [P_CFG_W-1:0]  cfg_i,
  input  logic                wr_i,
  input  logic [P_DATA_W-1:0] wdata_i,
  input  logic                ack_i,
  input  logic                pin_i,
  output logic                pin_o,
  output logic [P_DATA_W-1:0] result_o,
  output logic                flag_o,
  output logic                ovr_o
);
  localparam int unsigned CNT_W = $clog2(P_DATA_W + 3);
  localparam logic [P_ACC_W-1:0] HALF = P_ACC_W'(1) << (P_ACC_W - 1);

  logic                rx_en, tx_en;
  logic [P_ACC_W-1:0]  inc;
  logic [P_LEN_W-1:0]  len_m1;
  logic                cfg_unused;
  logic                tick, tx_start, rx_start, tx_busy, tx_line;
  logic [P_DATA_W-1:0] rx_data;

  assign rx_en      = (mode_i == logic'(MODE_RX));
  assign tx_en      = ~rx_en;
  assign inc        = cfg_i[P_CFG_W-1 -: P_ACC_W];
  assign len_m1     = cfg_i[P_LEN_W-1:0];
  assign cfg_unused = ^cfg_i[P_CFG_W-P_ACC_W-1:P_LEN_W];

  nco_phase_acc #(.W(P_ACC_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .load_i     (tx_start | rx_start),
    .load_val_i (rx_en ? HALF : '0),
    .tick_o     (tick)
  );

  nco_serial_tx #(.DATA_W(P_DATA_W), .LEN_W(P_LEN_W), .CNT_W(CNT_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en),
    .wr_i     (wr_i),
    .data_i   (wdata_i),
    .len_m1_i (len_m1),
    .tick_i   (tick),
    .start_o  (tx_start),
    .busy_o   (tx_busy),
    .line_o   (tx_line)
  );

  nco_serial_rx #(.DATA_W(P_DATA_W), .LEN_W(P_LEN_W), .CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en),
    .pin_i    (pin_i),
    .len_m1_i (len_m1),
    .tick_i   (tick),
    .ack_i    (ack_i),
    .start_o  (rx_start),
    .data_o   (rx_data),
    .flag_o   (flag_o),
    .ovr_o    (ovr_o)
  );

  assign pin_o    = rx_en ? 1'b1 : tx_line;
  assign result_o = rx_en ? rx_data : {tx_busy, {(P_DATA_W-1){1'b0}}};
endmodule

// File: rtl/nco_serial_pin_chk.sv
module nco_serial_pin_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_i,
  input logic              pin_i,
  input logic              pin_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_o,
  input logic              ovr_o
);
  logic busy;
  assign busy = result_o[DATA_W-1];

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !busy) |-> pin_o);

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && wr_i && !busy) |=> (mode_i || (busy && !pin_o)));

  p_stop_before_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && $past(!mode_i) && $fell(busy)) |-> $past(pin_o));

  p_flag_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !ack_i) |=> flag_o);

  p_ack_clears_ovr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ovr_o);

  p_ovr_with_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> flag_o);

  p_rx_line_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> pin_o);
endmodule

bind nco_serial_pin nco_serial_pin_chk #(.DATA_W(P_DATA_W), .CFG_W(P_CFG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .cfg_i    (cfg_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .ack_i    (ack_i),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .result_o (result_o),
  .flag_o   (flag_o),
  .ovr_o    (ovr_o)
);

// File: tb/sim_nco_serial_pin.sv
`timescale 1ns/1ps
module sim_nco_serial_pin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] cfg = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        ack = 1'b0;
  logic        pin_in = 1'b1;
  logic        pin_out;
  logic [31:0] result;
  logic        flag, ovr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nco_serial_pin u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cfg_i(cfg), .wr_i(wr),
    .wdata_i(wdata), .ack_i(ack), .pin_i(pin_in), .pin_o(pin_out),
    .result_o(result), .flag_o(flag), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int inc, input int nbm1);
    logic [31:0] c;
    c = '0;
    c[31:16] = inc[15:0];
    c[4:0]   = nbm1[4:0];
    return c;
  endfunction

  function automatic logic [31:0] len_mask(input int nb);
    return (nb >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
  endfunction

  function automatic int inc_for(input longint baud, input longint sysclk);
    return int'((65536 * baud + sysclk / 2) / sysclk);
  endfunction

  function automatic int frame_cycles(input int periods, input int inc);
    return int'((longint'(periods) * 65536 + inc - 1) / inc);
  endfunction

  function automatic int edge_at(input int k, input int inc);
    return int'((longint'(k) * 65536) / inc);
  endfunction

  // transmit one frame at an integer period and check bits and busy (R2 R3 R4 R5)
  task automatic tx_frame(input logic [31:0] d, input int nbm1, input int inc, input bit poke);
    int nb, per, total, j;
    logic exp_bit;
    nb = nbm1 + 1;
    per = 65536 / inc;
    total = per * (nb + 2);
    mode = 1'b0;
    cfg = mk_cfg(inc, nbm1);
    wdata = d;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int c = 0; c <= total; c++) begin
      if (c == 0) chk(result[31] && !pin_out, "R4 start low and busy", {result[31], 30'b0, pin_out}, 32'h8000_0000);
      if (c == total - 1) chk(result[31] == 1'b1, "R5 busy through stop", {31'b0, result[31]}, 32'd1);
      if (c == total) chk(result[31] == 1'b0, "R5 busy clears after stop", {31'b0, result[31]}, 32'd0);
      if (c < total && (c % per) == per / 2) begin
        j = c / per;
        if (j == 0) exp_bit = 1'b0;
        else if (j <= nb) exp_bit = d[j-1];
        else exp_bit = 1'b1;
        chk(pin_out == exp_bit, "R3 frame bit", {31'b0, pin_out}, {31'b0, exp_bit});
      end
      if (poke && c == per) begin
        wr = 1'b1;
        wdata = ~d;
      end else begin
        wr = 1'b0;
        wdata = d;
      end
      @(negedge clk);
    end
    chk(pin_out == 1'b1, "R3 idle high", {31'b0, pin_out}, 32'd1);
  endtask

  // frame duration at a fractional increment (R1)
  task automatic tx_len(input int inc, input int nbm1);
    int expn, got;
    mode = 1'b0;
    cfg = mk_cfg(inc, nbm1);
    wdata = 32'h55;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    expn = frame_cycles(nbm1 + 3, inc);
    got = -1;
    for (int c = 0; c <= expn + 5; c++) begin
      if (got < 0 && !result[31]) got = c;
      @(negedge clk);
    end
    chk(got == expn, "R1 fractional frame length", got, expn);
  endtask

  // drive one frame into the receiver
  task automatic rx_send(input logic [31:0] d, input int nbm1, input int inc);
    int nb, k, total;
    logic b;
    nb = nbm1 + 1;
    total = edge_at(nb + 2, inc);
    k = 0;
    for (int c = 0; c < total; c++) begin
      while (edge_at(k + 1, inc) <= c) k++;
      if (k == 0) b = 1'b0;
      else if (k <= nb) b = d[k-1];
      else b = 1'b1;
      pin_in = b;
      @(negedge clk);
    end
    pin_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic rx_check(input logic [31:0] d, input int nbm1, input int inc, input string req);
    logic [31:0] e;
    mode = 1'b1;
    cfg = mk_cfg(inc, nbm1);
    rx_send(d, nbm1, inc);
    e = d & len_mask(nbm1 + 1);
    chk(flag == 1'b1, {req, " flag set"}, {31'b0, flag}, 32'd1);
    chk(result == e, {req, " data"}, result, e);
    do_ack();
    chk(flag == 1'b0 && ovr == 1'b0, "R8 ack clears", {30'b0, flag, ovr}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    int nbm1, sel, inc;
    void'($urandom(32'd9157));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pin_out == 1'b1, "R11 pin high", {31'b0, pin_out}, 32'd1);
    chk(result == 32'd0 && !flag && !ovr, "R11 outputs clear", result, 32'd0);

    // directed transmit, 8 bits (R2 R3)
    tx_frame(32'h0000_00A5, 7, 8192, 1'b0);
    // write while busy is ignored (R5)
    tx_frame(32'h0000_0136, 8, 16384, 1'b1);
    // random transmit frames
    for (int n = 0; n < 6; n++) begin
      d = $urandom;
      nbm1 = int'($urandom % 32);
      sel = int'($urandom % 3);
      inc = (sel == 0) ? 4096 : (sel == 1) ? 8192 : 16384;
      tx_frame(d, nbm1, inc, n[0]);
    end
    // fractional rates (R1)
    tx_len(inc_for(3000000, 80000000), 7);
    tx_len(inc_for(115200, 80000000), 7);

    // receive directed and short words (R6 R2)
    rx_check(32'h0000_003C, 7, 8192, "R6 rx 8-bit");
    rx_check(32'hFFFF_FFF5, 4, 16384, "R6 rx zero-extend 5-bit");
    rx_check(32'hDEAD_BEEF, 31, 8192, "R2 rx 32-bit");

    // glitch shorter than half a bit (R7)
    mode = 1'b1;
    cfg = mk_cfg(8192, 7);
    pin_in = 1'b0;
    repeat (2) @(negedge clk);
    pin_in = 1'b1;
    repeat (30) @(negedge clk);
    chk(flag == 1'b0, "R7 glitch rejected", {31'b0, flag}, 32'd0);
    rx_check(32'h0000_0081, 7, 8192, "R7 rx after glitch");

    // overrun (R9)
    cfg = mk_cfg(8192, 7);
    rx_send(32'h11, 7, 8192);
    rx_send(32'h2E, 7, 8192);
    chk(flag && ovr, "R9 overrun flagged", {30'b0, flag, ovr}, 32'd3);
    chk(result == 32'h2E, "R9 newest kept", result, 32'h2E);
    do_ack();
    chk(!flag && !ovr, "R8 ack clears overrun", {30'b0, flag, ovr}, 32'd0);

    // random receive, including 3 Mbaud at 80 MHz (R1)
    for (int n = 0; n < 6; n++) begin
      d = $urandom;
      nbm1 = int'($urandom % 32);
      inc = n[0] ? 16384 : 8192;
      rx_check(d, nbm1, inc, "R6 rx random");
    end
    rx_check(32'h0000_00C3, 7, inc_for(3000000, 80000000), "R1 rx fractional");

    // receive mode ignores writes and holds line high (R10)
    mode = 1'b1;
    cfg = mk_cfg(8192, 7);
    wdata = 32'h0;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int c = 0; c < 12; c++) begin
      chk(pin_out == 1'b1, "R10 line high in rx", {31'b0, pin_out}, 32'd1);
      @(negedge clk);
    end
    mode = 1'b0;
    @(negedge clk);
    chk(result[31] == 1'b0 && pin_out, "R10 write ignored", {result[31], 30'b0, pin_out}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule